// File: doc/BRIEF.md
# Receive Delay Line Calibration and Phase Tuner

This controller sets up a programmable receive-clock delay line in two passes. A start pulse begins the first pass, which calibrates the line. The delay-unit code steps upward from zero. While it steps, the phase select is pinned one position above the last tap, and the sampler stays enabled. At each step the controller waits for the line to report a measured length vector. It takes the first unit whose length is non-zero and still inside the tap range. The index of the highest set bit in that length becomes the largest usable phase.

The second pass sweeps the phase select from zero up to that largest phase, with only the delay enabled. For each phase, an external tuning-pattern checker answers a request with pass or fail. The controller remembers the longest unbroken run of passing phases. It then programs the phase that sits at the centre of that run, rounded toward the start of the run. The result is reported as either a done flag or an error code, and it is held until the next start.

Top module: `dlcal_tuner`

## Requirements
- R1: After reset, `busy`, `done`, `err_code`, `dl_unit`, `dl_phase`, `dl_sampler_en`, `dl_delay_en` and `chk_req` are all zero.
- R2: During calibration the unit code starts at 0 and rises by exactly one per failed step. Throughout calibration, `dl_phase` equals TAPS+1 (12 by default), and `dl_sampler_en` and `dl_delay_en` are both 1.
- R3: If `len_valid` has not been seen within TIMEOUT_CYC cycles of a unit step, that unit is skipped and the sweep moves to the next unit. A response that arrives in the last cycle of the window still counts.
- R4: A unit is accepted when its length vector is non-zero and its top bit (bit TAPS, bit 11 by default) is clear. The first accepted unit ends the sweep and stays on `dl_unit` and `res_unit`. A valid length that fails this test moves the sweep on at once.
- R5: `res_max` equals the bit index of the highest set bit in the accepted length vector.
- R6: If no unit up to 2^UNIT_W-1 is accepted, `err_code` becomes 1, `done` stays 0, and `dl_delay_en` drops to 0.
- R7: The phase sweep visits phases 0 through `res_max` in ascending order, exactly once each, with `dl_sampler_en` 0 and `dl_delay_en` 1. `chk_req` is held, with the phase unchanged, until `chk_ack`.
- R8: On success `done` is 1, and `res_phase` and `dl_phase` equal the end phase of the longest passing run minus half that run's length, rounded down. If two runs are equally long, the earlier one wins.
- R9: If no phase passes, `err_code` becomes 2 and `done` stays 0.
- R10: `done` and a non-zero `err_code` never occur together. Each is held until the next accepted start. A start that arrives while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin calibration and tuning (taken only when idle) |
| len_vec | input | TAPS+1 | Measured delay-line length vector |
| len_valid | input | 1 | Length vector is valid this cycle |
| chk_ack | input | 1 | Tuning checker has answered |
| chk_pass | input | 1 | Tuning checker verdict, qualified by chk_ack |
| dl_unit | output | UNIT_W | Delay-unit code to the line |
| dl_phase | output | clog2(TAPS+2) | Phase select to the line |
| dl_sampler_en | output | 1 | Sampler enable to the line |
| dl_delay_en | output | 1 | Delay enable to the line |
| chk_req | output | 1 | Request a tuning-pattern check at dl_phase |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Tuning finished successfully |
| err_code | output | 2 | 0 none, 1 calibration failed, 2 no passing phase |
| res_unit | output | UNIT_W | Accepted delay unit |
| res_phase | output | clog2(TAPS+2) | Chosen sampling phase |
| res_max | output | clog2(TAPS+2) | Largest usable phase |

## Verification
The bench keeps the default unit width and tap count, so the length vector is 12 bits, the forced calibration select is 12 and the largest phase can reach 10. It sets TIMEOUT_CYC to 16. With that short window, a full exhaustion of all 128 units without an accepted length finishes in about two thousand cycles. The same setting puts the exact timeout boundary within easy reach: a response latency of 15 cycles is accepted and one of 16 is skipped. Pass patterns cover ties between runs, a single passing phase at the top of the range, a one-phase sweep with no pass, and a start pulse that arrives in the middle of a sweep.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CAL  = 3'd1,
        ST_ASK  = 3'd2,
        ST_STEP = 3'd3,
        ST_FIN  = 3'd4
    } dlcal_state_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_CAL    = 2'd1,
        ERR_NOTUNE = 2'd2
    } dlcal_err_e;

    // Offset added to the tap count to form the calibration phase select.
    localparam int CAL_SEL_OFFSET = 1;

endpackage

// File: rtl/dlcal_len_eval.sv
module dlcal_len_eval #(
    parameter int LEN_W = 12,
    parameter int IDX_W = 4
) (
    input  logic [LEN_W-1:0] len_vec,
    output logic             len_ok,
    output logic [IDX_W-1:0] len_msb
);
    // Accepted: some bit set and the overflow bit (top bit) clear.
    assign len_ok = (|len_vec) && !len_vec[LEN_W-1];

    always_comb begin
        len_msb = '0;
        for (int i = 0; i < LEN_W; i++) begin
            if (len_vec[i]) len_msb = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dlcal_run_track.sv
module dlcal_run_track #(
    parameter int PH_W  = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  logic             pass,
    input  logic [PH_W-1:0]  phase,
    output logic [CNT_W-1:0] best_len,
    output logic [PH_W-1:0]  best_end
);
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_nx;

    assign run_nx = run_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q    <= '0;
            best_len <= '0;
            best_end <= '0;
        end else if (upd) begin
            if (pass) begin
                run_q <= run_nx;
                if (run_nx > best_len) begin
                    best_len <= run_nx;
                    best_end <= phase;
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/dlcal_tuner.sv
module dlcal_tuner
    import dlcal_pkg::*;
#(
    parameter int UNIT_W      = 7,
    parameter int TAPS        = 11,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [TAPS:0]                 len_vec,
    input  logic                          len_valid,
    input  logic                          chk_ack,
    input  logic                          chk_pass,
    output logic [UNIT_W-1:0]             dl_unit,
    output logic [$clog2(TAPS+2)-1:0]     dl_phase,
    output logic                          dl_sampler_en,
    output logic                          dl_delay_en,
    output logic                          chk_req,
    output logic                          busy,
    output logic                          done,
    output logic [1:0]                    err_code,
    output logic [UNIT_W-1:0]             res_unit,
    output logic [$clog2(TAPS+2)-1:0]     res_phase,
    output logic [$clog2(TAPS+2)-1:0]     res_max
);
    localparam int LEN_W     = TAPS + 1;
    localparam int PH_W      = $clog2(TAPS + 2);
    localparam int CNT_W     = PH_W + 1;
    localparam int TMR_W     = $clog2(TIMEOUT_CYC + 1);
    localparam logic [UNIT_W-1:0] UNIT_LAST = {UNIT_W{1'b1}};
    localparam logic [PH_W-1:0]   CAL_SEL   = PH_W'(TAPS + CAL_SEL_OFFSET);
    localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(TIMEOUT_CYC - 1);

    dlcal_state_e      state_q;
    dlcal_err_e        err_q;
    logic [UNIT_W-1:0] unit_q;
    logic [PH_W-1:0]   phase_q;
    logic [PH_W-1:0]   max_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              done_q;

    logic              len_ok;
    logic [PH_W-1:0]   len_msb;
    logic [CNT_W-1:0]  best_len;
    logic [PH_W-1:0]   best_end;
    logic [CNT_W-1:0]  centre_wide;
    logic [PH_W-1:0]   centre;
    logic              win_clr;
    logic              win_upd;

    dlcal_len_eval #(
        .LEN_W(LEN_W),
        .IDX_W(PH_W)
    ) u_len (
        .len_vec(len_vec),
        .len_ok (len_ok),
        .len_msb(len_msb)
    );

    assign win_clr = (state_q == ST_IDLE) && start;
    assign win_upd = (state_q == ST_ASK) && chk_ack;

    dlcal_run_track #(
        .PH_W (PH_W),
        .CNT_W(CNT_W)
    ) u_win (
        .clk     (clk),
        .rst     (rst),
        .clr     (win_clr),
        .upd     (win_upd),
        .pass    (chk_pass),
        .phase   (phase_q),
        .best_len(best_len),
        .best_end(best_end)
    );

    // Centre of the longest run, rounded toward its first phase.
    assign centre_wide = {1'b0, best_end} - (best_len >> 1);
    assign centre      = centre_wide[PH_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
            unit_q  <= '0;
            phase_q <= '0;
            max_q   <= '0;
            tmr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_CAL;
                        unit_q  <= '0;
                        phase_q <= '0;
                        tmr_q   <= '0;
                        done_q  <= 1'b0;
                        err_q   <= ERR_NONE;
                    end
                end
                ST_CAL: begin
                    if (len_valid && len_ok) begin
                        state_q <= ST_ASK;
                        max_q   <= len_msb;
                        phase_q <= '0;
                    end else if (len_valid || (tmr_q == TMR_LAST)) begin
                        tmr_q <= '0;
                        if (unit_q == UNIT_LAST) begin
                            state_q <= ST_IDLE;
                            err_q   <= ERR_CAL;
                        end else begin
                            unit_q <= unit_q + UNIT_W'(1);
                        end
                    end else begin
                        tmr_q <= tmr_q + TMR_W'(1);
                    end
                end
                ST_ASK: begin
                    if (chk_ack) begin
                        state_q <= (phase_q == max_q) ? ST_FIN : ST_STEP;
                    end
                end
                ST_STEP: begin
                    phase_q <= phase_q + PH_W'(1);
                    state_q <= ST_ASK;
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                    if (best_len == '0) begin
                        err_q <= ERR_NOTUNE;
                    end else begin
                        done_q  <= 1'b1;
                        phase_q <= centre;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign dl_unit       = unit_q;
    assign dl_phase      = (state_q == ST_CAL) ? CAL_SEL : phase_q;
    assign dl_sampler_en = (state_q == ST_CAL);
    assign dl_delay_en   = (state_q != ST_IDLE) || done_q;
    assign chk_req       = (state_q == ST_ASK);
    assign busy          = (state_q != ST_IDLE);
    assign done          = done_q;
    assign err_code      = err_q;
    assign res_unit      = unit_q;
    assign res_phase     = phase_q;
    assign res_max       = max_q;
endmodule

// File: rtl/dlcal_tuner_chk.sv
module dlcal_tuner_chk #(
    parameter int UNIT_W = 7,
    parameter int TAPS   = 11
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start,
    input logic [UNIT_W-1:0]         dl_unit,
    input logic [$clog2(TAPS+2)-1:0] dl_phase,
    input logic                      dl_sampler_en,
    input logic                      dl_delay_en,
    input logic                      chk_req,
    input logic                      chk_ack,
    input logic                      busy,
    input logic                      done,
    input logic [1:0]                err_code,
    input logic [$clog2(TAPS+2)-1:0] res_phase,
    input logic [$clog2(TAPS+2)-1:0] res_max
);
    localparam int PH_W = $clog2(TAPS + 2);

    AST_CAL_SEL_FORCED: assert property (@(posedge clk) disable iff (rst)
        dl_sampler_en |-> (dl_phase == PH_W'(TAPS + 1)) && dl_delay_en); // R2

    AST_CAL_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (dl_sampler_en && $past(dl_sampler_en)) |->
            ((dl_unit == $past(dl_unit)) || (dl_unit == $past(dl_unit) + UNIT_W'(1)))); // R2

    AST_REQ_IN_SWEEP: assert property (@(posedge clk) disable iff (rst)
        chk_req |-> (dl_phase <= res_max) && !dl_sampler_en && dl_delay_en); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (chk_req && !chk_ack) |=> chk_req && $stable(dl_phase)); // R7

    AST_FINAL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        done |-> (res_phase <= res_max) && !busy); // R8

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((err_code != 2'd0) && !start) |=> $stable(err_code)); // R6

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && (err_code != 2'd0))); // R10

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R10
endmodule

bind dlcal_tuner dlcal_tuner_chk #(
    .UNIT_W(UNIT_W),
    .TAPS  (TAPS)
) u_dlcal_tuner_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .dl_unit      (dl_unit),
    .dl_phase     (dl_phase),
    .dl_sampler_en(dl_sampler_en),
    .dl_delay_en  (dl_delay_en),
    .chk_req      (chk_req),
    .chk_ack      (chk_ack),
    .busy         (busy),
    .done         (done),
    .err_code     (err_code),
    .res_phase    (res_phase),
    .res_max      (res_max)
);

// File: tb/test_dlcal_tuner.sv
module test_dlcal_tuner;
    localparam int UNIT_W = 7;
    localparam int TAPS   = 11;
    localparam int TMO    = 16;
    localparam int LEN_W  = TAPS + 1;
    localparam int PH_W   = $clog2(TAPS + 2);
    localparam int NUNIT  = 1 << UNIT_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  len_vec = '0;
    logic              len_valid = 1'b0;
    logic              chk_ack = 1'b0;
    logic              chk_pass = 1'b0;
    logic [UNIT_W-1:0] dl_unit;
    logic [PH_W-1:0]   dl_phase;
    logic              dl_sampler_en;
    logic              dl_delay_en;
    logic              chk_req;
    logic              busy;
    logic              done;
    logic [1:0]        err_code;
    logic [UNIT_W-1:0] res_unit;
    logic [PH_W-1:0]   res_phase;
    logic [PH_W-1:0]   res_max;

    dlcal_tuner #(
        .UNIT_W     (UNIT_W),
        .TAPS       (TAPS),
        .TIMEOUT_CYC(TMO)
    ) i_dlcal_tuner (
        .clk(clk), .rst(rst), .start(start), .len_vec(len_vec), .len_valid(len_valid),
        .chk_ack(chk_ack), .chk_pass(chk_pass), .dl_unit(dl_unit), .dl_phase(dl_phase),
        .dl_sampler_en(dl_sampler_en), .dl_delay_en(dl_delay_en), .chk_req(chk_req),
        .busy(busy), .done(done), .err_code(err_code), .res_unit(res_unit),
        .res_phase(res_phase), .res_max(res_max)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Delay-line and tuning-checker models, driven by these tables.
    int               resp_lat [0:NUNIT-1];
    logic [LEN_W-1:0] resp_val [0:NUNIT-1];
    bit               pat [0:15];
    int               ack_dly = 0;

    int unitq[$];
    int phq[$];
    bit prev_samp = 0;
    int prev_unit = 0;
    int lcnt = 0;
    int wcnt = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            len_valid = 0; chk_ack = 0; prev_samp = 0; lcnt = 0; wcnt = 0;
        end else begin
            // per-clock relations
            if (dl_sampler_en)
                check(dl_phase == PH_W'(TAPS + 1) && dl_delay_en, "R2 cal select", dl_phase, TAPS + 1);
            if (chk_req)
                check(!dl_sampler_en && dl_delay_en, "R7 sweep enables", dl_sampler_en, 0);
            check(!(done && err_code != 0), "R10 exclusive", err_code, 0);
            // delay line
            if (dl_sampler_en) begin
                if (!prev_samp || int'(dl_unit) != prev_unit) begin
                    lcnt = 0;
                    unitq.push_back(int'(dl_unit));
                end else begin
                    lcnt++;
                end
                if (resp_lat[dl_unit] >= 0 && lcnt == resp_lat[dl_unit]) begin
                    len_valid = 1; len_vec = resp_val[dl_unit];
                end else begin
                    len_valid = 0; len_vec = '0;
                end
            end else begin
                len_valid = 0; len_vec = '0;
            end
            prev_samp = dl_sampler_en;
            prev_unit = int'(dl_unit);
            // tuning checker
            if (chk_req && !chk_ack) begin
                if (wcnt == ack_dly) begin
                    chk_ack = 1; chk_pass = pat[dl_phase]; wcnt = 0;
                    phq.push_back(int'(dl_phase));
                end else begin
                    wcnt++;
                end
            end else begin
                chk_ack = 0; chk_pass = 0;
            end
        end
    end

    task automatic clear_tables();
        for (int i = 0; i < NUNIT; i++) begin resp_lat[i] = -1; resp_val[i] = '0; end
        for (int i = 0; i < 16; i++) pat[i] = 0;
    endtask

    function automatic void ref_cal(output int u, output int mx);
        u = -1; mx = 0;
        for (int i = 0; i < NUNIT; i++) begin
            if (resp_lat[i] >= 0 && resp_lat[i] < TMO && resp_val[i] != 0 && !resp_val[i][LEN_W-1]) begin
                u = i;
                for (int b = 0; b < LEN_W; b++) if (resp_val[i][b]) mx = b;
                break;
            end
        end
    endfunction

    function automatic void ref_window(input int mx, output int best, output int fin);
        int run = 0;
        int endp = 0;
        best = 0;
        for (int p = 0; p <= mx; p++) begin
            if (pat[p]) begin
                run++;
                if (run > best) begin best = run; endp = p; end
            end else run = 0;
        end
        fin = endp - best / 2;
    endfunction

    task automatic run_scn(input int extra_at);
        int ub = unitq.size();
        int pb = phq.size();
        int eu, emx, best, fin;
        int cyc = 0;
        best = 0; fin = 0;
        ref_cal(eu, emx);
        if (eu >= 0) ref_window(emx, best, fin);
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        check(busy && !done && err_code == 0, "R10 start clears result", {busy, done}, 2);
        while (!(done || err_code != 0) && cyc < 20000) begin
            if (cyc == extra_at) begin
                check(busy, "R10 start while busy", busy, 1);
                start = 1;
            end else start = 0;
            @(negedge clk);
            cyc++;
        end
        start = 0;
        if (eu < 0) begin
            check(err_code == 2'd1, "R6 cal error", err_code, 1);
            check(!done && !dl_delay_en, "R6 done/delay low", {done, dl_delay_en}, 0);
            check(unitq.size() - ub == NUNIT, "R3 all units tried", unitq.size() - ub, NUNIT);
            for (int i = 0; i < unitq.size() - ub; i++)
                check(unitq[ub + i] == i, "R2 unit order", unitq[ub + i], i);
        end else begin
            check(unitq.size() - ub == eu + 1, "R3 units tried", unitq.size() - ub, eu + 1);
            for (int i = 0; i < unitq.size() - ub; i++)
                check(unitq[ub + i] == i, "R2 unit order", unitq[ub + i], i);
            check(res_unit == eu && dl_unit == eu, "R4 accepted unit", res_unit, eu);
            check(res_max == emx, "R5 max phase", res_max, emx);
            check(phq.size() - pb == emx + 1, "R7 phases asked", phq.size() - pb, emx + 1);
            for (int i = 0; i < phq.size() - pb; i++)
                check(phq[pb + i] == i, "R7 phase order", phq[pb + i], i);
            if (best == 0) begin
                check(err_code == 2'd2 && !done, "R9 no tuning point", err_code, 2);
            end else begin
                check(done && err_code == 0, "R8 done", done, 1);
                check(res_phase == fin && dl_phase == fin, "R8 centre phase", res_phase, fin);
                check(dl_delay_en && !dl_sampler_en, "R8 final enables", dl_delay_en, 1);
            end
        end
    endtask

    initial begin
        clear_tables();
        repeat (3) @(negedge clk);
        check(!busy && !done && err_code == 0 && dl_unit == 0 && dl_phase == 0 &&
              !dl_sampler_en && !dl_delay_en && !chk_req, "R1 reset state", busy, 0);
        rst = 0;
        @(negedge clk);
        check(!busy && !dl_delay_en && !chk_req, "R1 idle after reset", busy, 0);

        // A: zero, timeout at exact limit, overflow, accept at last window cycle
        clear_tables();
        resp_lat[0] = 3;       resp_val[0] = 12'h000;
        resp_lat[1] = TMO;     resp_val[1] = 12'h0F0;
        resp_lat[2] = TMO - 1; resp_val[2] = 12'h800;
        resp_lat[3] = TMO - 1; resp_val[3] = 12'h0F0;
        pat[0] = 1; pat[1] = 1; pat[3] = 1; pat[4] = 1; pat[5] = 1; pat[7] = 1;
        ack_dly = 1;
        run_scn(-1);
        repeat (10) @(negedge clk);
        check(done && err_code == 0 && res_phase == 4, "R10 result held", res_phase, 4);

        // B: full range, tie between runs, start pulse mid-sweep
        clear_tables();
        resp_lat[0] = 0; resp_val[0] = 12'h7FF;
        pat[0] = 1; pat[1] = 1; pat[3] = 1; pat[4] = 1; pat[10] = 1;
        ack_dly = 2;
        run_scn(30);

        // C: single phase, no pass
        clear_tables();
        resp_lat[0] = 0; resp_val[0] = 12'h001;
        ack_dly = 0;
        run_scn(-1);
        repeat (5) @(negedge clk);
        check(err_code == 2'd2 && !done, "R10 error held", err_code, 2);

        // E: only the top phase passes
        clear_tables();
        for (int i = 0; i < 5; i++) begin resp_lat[i] = 1; resp_val[i] = 12'h000; end
        resp_lat[5] = 2; resp_val[5] = 12'h01F;
        pat[4] = 1;
        ack_dly = 3;
        run_scn(-1);

        // D: nothing usable anywhere
        clear_tables();
        resp_lat[NUNIT-1] = 0; resp_val[NUNIT-1] = 12'hFFF;
        resp_lat[7] = 4;       resp_val[7] = 12'h000;
        run_scn(-1);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule